// File: doc/BRIEF.md
# Serial Frame Transmitter with Idle Preamble and Break

This block turns parallel words into asynchronous serial frames on a single output line. A caller drops a word into a one-entry holding buffer. At the next bit boundary the word moves into a shift register. It then leaves the block framed by a low start bit and a high stop bit, least significant bit first. A frame carries either 8 data bits (10 line bits) or 9 data bits (11 line bits). The time base comes from an external bit tick, and the line changes only on clock edges where that tick is high.

Each time the transmit enable rises, the block first sends a full frame's worth of high bits as an idle preamble, before anything else. A break request makes it send frames of all-low bits. A frame already in progress is always finished before a break starts. Break frames then follow back to back for as long as the request stays high. A short request pulse produces one or two break frames. After that the line goes back to idle, or the block continues with buffered data.

The controller has five states:
- OFF: disabled, line high.
- IDLE: enabled, line high, waiting for work.
- PREAMBLE: sending a frame of ones.
- DATA: sending a framed word.
- BREAK: sending a frame of zeros.

The transitions are:
- **enable-up**: OFF to IDLE.
- **enable-down**: any state to OFF.
- **launch**: IDLE to PREAMBLE, BREAK or DATA, taken at a tick.
- **chain**: from the last bit of one frame straight into the next frame at a tick.
- **settle**: from the last bit of a frame to IDLE when nothing is pending.

Top module: `serial_tx_top`

## Requirements
- R1: After reset the line is high, buf_empty is 1 and tx_done is 1.
- R2: While tx_en is low the line is high. Dropping tx_en abandons any frame in progress, and the line is high from the next clock.
- R3: The line changes only at a clock edge where bit_tick is 1. Each bit lasts one tick, and a new frame starts at the tick right after the previous frame's last bit.
- R4: A data frame is a 0 start bit, then data bits LSB first, then a 1 stop bit. With len_wide=0 it carries wr_data[7:0] (10 bits). With len_wide=1 it carries wr_data[8:0] (11 bits).
- R5: Every rising edge of tx_en queues a preamble of 10 (len_wide=0) or 11 (len_wide=1) ones, sent as the first frame after enabling.
- R6: A break frame is 10 or 11 zeros, chosen by len_wide. A break requested during a frame starts only after that frame's stop bit.
- R7: Break frames repeat back to back while brk_req stays high. A pulse seen outside a break frame yields exactly one break frame. After the break the line returns to idle or goes on to buffered data.
- R8: At a frame boundary the preamble has priority over break, and break has priority over buffered data.
- R9: A write clears buf_empty. buf_empty sets on the clock after the buffer's word moves into the shift register. A write on that same clock keeps the new word and leaves buf_empty at 0.
- R10: tx_done is 1 exactly when no frame is on the line and the buffer is empty, with no preamble or break pending.
- R11: A write to a full buffer replaces the held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; each rising edge queues a preamble |
| brk_req | input | 1 | Break request |
| len_wide | input | 1 | 1: 9 data bits (11-bit frames); 0: 8 data bits (10-bit frames) |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | 9 | Word to send |
| bit_tick | input | 1 | One-cycle bit-time pulse |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Nothing on the line and nothing pending |

## Verification
The hardest situation to reach is a break request that is released part-way through a break frame while a data word is waiting in the buffer. Here the break must end at the frame boundary, and the waiting word must follow with no gap. The stimulus starts a data frame, raises the request mid-frame, and writes a new word once the first word has left the buffer. It counts bits across two break frames, drops the request in the middle of the second, and then expects the waiting frame at the very next tick. A separate test drives a buffer write on the same clock as a load, to check that the write is not lost. Sweeps over every 8-bit and 9-bit word, sent back to back, cover the frame format.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_BRK
    } tx_state_e;

    typedef enum logic [1:0] {
        FK_NONE,
        FK_PRE,
        FK_BRK,
        FK_DATA
    } frame_kind_e;

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] held,
    output logic          empty
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held  <= '0;
            empty <= 1'b1;
        end else if (wr_stb) begin
            held  <= wr_data;
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end

    // R9: a move without a simultaneous write leaves the buffer empty
    p_empty_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wr_stb |=> empty);

    // R11: a write always lands, full or not
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !empty && held == $past(wr_data));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int FW = 11,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_word,
    input  logic [CW-1:0] load_last,
    input  logic          advance,
    output logic          bit_out,
    output logic          at_last
);

    logic [FW-1:0] sh_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_word;
            left_q <= load_last;
        end else if (advance) begin
            sh_q   <= {1'b1, sh_q[FW-1:1]};
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_out = sh_q[0];
    assign at_last = (left_q == '0);

    // R3: the controller never steps past a frame's last bit
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |-> left_q != '0);

    // R4: the remaining bit count stays within one frame
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CW'(FW - 1));

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top #(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                brk_req,
    input  logic                len_wide,
    input  logic                wr_stb,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                bit_tick,
    output logic                txd,
    output logic                buf_empty,
    output logic                tx_done
);
    import sertx_pkg::*;

    localparam int FRAME_MAX = DATA_MAX + 2;
    localparam int CNT_W     = $clog2(FRAME_MAX);

    tx_state_e     state_q, state_d;
    frame_kind_e   kind;
    logic          en_q;
    logic          pre_pend_q;
    logic          brk_lat_q;
    logic          in_frame;
    logic          boundary;
    logic          load;
    logic          take;
    logic          advance;
    logic          bit_out;
    logic          at_last;
    logic [DATA_MAX-1:0]  held;
    logic [FRAME_MAX-1:0] data_word;
    logic [FRAME_MAX-1:0] load_word;
    logic [CNT_W-1:0]     load_last;

    sertx_holdbuf #(.DW(DATA_MAX)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .held    (held),
        .empty   (buf_empty)
    );

    sertx_shifter #(.FW(FRAME_MAX), .CW(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .load_last (load_last),
        .advance   (advance),
        .bit_out   (bit_out),
        .at_last   (at_last)
    );

    assign in_frame = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_BRK);
    assign boundary = bit_tick && ((state_q == ST_IDLE) || (in_frame && at_last));

    // what goes next at a boundary: preamble, then break, then data
    always_comb begin
        if (pre_pend_q)                kind = FK_PRE;
        else if (brk_req || brk_lat_q) kind = FK_BRK;
        else if (!buf_empty)           kind = FK_DATA;
        else                           kind = FK_NONE;
    end

    // data frame: start 0, data LSB first, stop 1, padded with ones
    always_comb begin
        data_word    = '1;
        data_word[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (len_wide || i < DATA_MAX - 1) begin
                data_word[i+1] = held[i];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state: enable-up, enable-down, launch, chain, settle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (tx_en) state_d = ST_IDLE;
            end
            ST_IDLE, ST_PRE, ST_DATA, ST_BRK: begin
                if (!tx_en) begin
                    state_d = ST_OFF;
                end else if (boundary) begin
                    unique case (kind)
                        FK_PRE:  state_d = ST_PRE;
                        FK_BRK:  state_d = ST_BRK;
                        FK_DATA: state_d = ST_DATA;
                        FK_NONE: state_d = ST_IDLE;
                    endcase
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        load      = tx_en && boundary && (kind != FK_NONE);
        take      = load && (kind == FK_DATA);
        advance   = tx_en && in_frame && bit_tick && !at_last;
        load_last = len_wide ? CNT_W'(FRAME_MAX - 1) : CNT_W'(FRAME_MAX - 2);
        unique case (kind)
            FK_PRE:  load_word = '1;
            FK_BRK:  load_word = '0;
            FK_DATA: load_word = data_word;
            FK_NONE: load_word = '1;
        endcase
        txd     = in_frame ? bit_out : 1'b1;
        tx_done = ((state_q == ST_OFF) || (state_q == ST_IDLE)) && buf_empty
                  && !pre_pend_q && !brk_lat_q;
    end

    // pending preamble and break latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            pre_pend_q <= 1'b0;
            brk_lat_q  <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (!tx_en)                         pre_pend_q <= 1'b0;
            else if (!en_q)                     pre_pend_q <= 1'b1;
            else if (load && kind == FK_PRE)    pre_pend_q <= 1'b0;

            if (!tx_en)                         brk_lat_q <= 1'b0;
            else if (load && kind == FK_BRK)    brk_lat_q <= 1'b0;
            else if (brk_req && state_q != ST_BRK) brk_lat_q <= 1'b1;
        end
    end

    p_mark_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && !bit_tick |=> $stable(txd));

    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);

    p_pre_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PRE |-> txd);

    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BRK |-> !txd);

    p_frame_finishes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DATA && !at_last |=> state_q == ST_DATA || state_q == ST_OFF);

    p_done_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> buf_empty);

endmodule

// File: tb/serial_tx_top_tb_top.sv
module serial_tx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       len_wide = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       buf_empty;
    logic       tx_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    serial_tx_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .brk_req  (brk_req),
        .len_wide (len_wide),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .bit_tick (bit_tick),
        .txd      (txd),
        .buf_empty(buf_empty),
        .tx_done  (tx_done)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] dframe(input logic [8:0] d, input bit wide);
        logic [10:0] w;
        w = '1;
        w[0] = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (wide || i < 8) w[i+1] = d[i];
        end
        return w;
    endfunction

    // one bit time: tick for one clock, sample, then a quiet clock (R3)
    task automatic do_tick(output logic b);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        b = txd;
        @(negedge clk);
        check("R3 line steady without tick", txd, b);
    endtask

    task automatic expect_bits(input logic [10:0] w, input int from, input int n, input string req);
        logic b;
        for (int i = from; i < n; i++) begin
            do_tick(b);
            check(req, b, w[i]);
        end
    endtask

    task automatic write_word(input logic [8:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic b;
        repeat (3) @(negedge clk);
        check("R1 reset txd", txd, 1);
        check("R1 reset buf_empty", buf_empty, 1);
        check("R1 reset tx_done", tx_done, 1);
        rst_n = 1'b1;

        // R2: disabled, line stays high even with data and ticks
        write_word(9'h0A5);
        check("R9 write clears empty", buf_empty, 0);
        check("R10 done low with data", tx_done, 0);
        for (int i = 0; i < 4; i++) begin
            do_tick(b);
            check("R2 disabled line high", b, 1);
        end
        // R11: overwrite while full
        write_word(9'h03C);
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        check("R10 done low with preamble pending", tx_done, 0);
        expect_bits(11'h7FF, 0, 10, "R5 preamble ones narrow");
        expect_bits(dframe(9'h03C, 0), 0, 10, "R11 overwritten word sent");
        do_tick(b);
        check("R10 idle line", b, 1);
        check("R10 done after frame", tx_done, 1);

        // R4/R3/R9: sweep every word, back to back, both lengths
        for (int wide = 0; wide < 2; wide++) begin
            int n;
            int maxv;
            n    = wide ? 11 : 10;
            maxv = wide ? 511 : 255;
            len_wide = wide[0];
            write_word(9'd0);
            for (int v = 0; v <= maxv; v++) begin
                logic [10:0] w;
                w = dframe(9'(v), wide[0]);
                do_tick(b);
                check("R4 start bit", b, 0);
                check("R9 empty after move", buf_empty, 1);
                check("R10 done low in frame", tx_done, 0);
                if (v < maxv) write_word(9'(v + 1));
                expect_bits(w, 1, n, wide ? "R4 wide frame bit" : "R4 narrow frame bit");
            end
            do_tick(b);
            check("R3 idle after stream", b, 1);
            check("R10 done after stream", tx_done, 1);
        end

        // R6/R7/R8: break held across two frames, data waiting
        len_wide = 1'b0;
        write_word(9'h055);
        expect_bits(dframe(9'h055, 0), 0, 4, "R4 frame head");
        @(negedge clk) brk_req = 1'b1;
        write_word(9'h00F);
        expect_bits(dframe(9'h055, 0), 4, 10, "R6 frame completes before break");
        expect_bits(11'h000, 0, 10, "R6 first break frame");
        expect_bits(11'h000, 0, 3, "R7 second break frame head");
        @(negedge clk) brk_req = 1'b0;
        expect_bits(11'h000, 3, 10, "R7 second break frame tail");
        expect_bits(dframe(9'h00F, 0), 0, 10, "R8 data after break");
        do_tick(b);
        check("R7 idle after data", b, 1);
        check("R10 done after break and data", tx_done, 1);

        // R7: short pulse inside a data frame gives one break frame
        write_word(9'h081);
        expect_bits(dframe(9'h081, 0), 0, 3, "R4 frame head");
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk);
        @(negedge clk) brk_req = 1'b0;
        check("R10 done low with break pending", tx_done, 0);
        expect_bits(dframe(9'h081, 0), 3, 10, "R6 frame completes");
        expect_bits(11'h000, 0, 10, "R7 single break frame");
        expect_bits(11'h7FF, 0, 10, "R7 line back to idle");
        check("R10 done after pulse", tx_done, 1);

        // R2 abort, then R5/R8 preamble before break, wide frames
        write_word(9'h000);
        do_tick(b);
        check("R4 start bit before abort", b, 0);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        check("R2 abort line high", txd, 1);
        len_wide = 1'b1;
        brk_req  = 1'b1;
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        expect_bits(11'h7FF, 0, 11, "R8 preamble before break");
        expect_bits(11'h000, 0, 5, "R6 wide break head");
        @(negedge clk) brk_req = 1'b0;
        expect_bits(11'h000, 5, 11, "R6 wide break tail");
        do_tick(b);
        check("R7 idle after wide break", b, 1);
        check("R10 done after wide break", tx_done, 1);

        // R9: write on the same clock as a load
        len_wide = 1'b0;
        write_word(9'h012);
        @(negedge clk) begin bit_tick = 1'b1; wr_stb = 1'b1; wr_data = 9'h034; end
        @(negedge clk) begin bit_tick = 1'b0; wr_stb = 1'b0; end
        check("R9 load started", txd, 0);
        check("R9 same-clock write kept", buf_empty, 0);
        @(negedge clk);
        expect_bits(dframe(9'h012, 0), 1, 10, "R9 first word");
        expect_bits(dframe(9'h034, 0), 0, 10, "R9 second word");
        do_tick(b);
        check("R10 final idle", b, 1);
        check("R10 final done", tx_done, 1);

        summary();
        $finish;
    end

endmodule